// File: doc/BRIEF.md
# Four-Operation Small-Operand Calculator

This block is the arithmetic core of a small calculator. A user keys in two unsigned operands and then picks one of four operations. Every key press arrives as a one-cycle entry strobe, together with a data value and an operation code. The block stores the two operands, waits for the operation, and then computes the answer in a single cycle. It holds the result, a remainder, a borrow flag and a divide-by-zero flag until the next entry begins.

Division does not use an iterative divider. It uses a fully combinational chain of 2^W compare-and-subtract stages. The divisor is taken away from a running copy of the dividend, and the stages count how many subtractions were made. The first stage that finds the running value below the divisor latches the count as the quotient and the running value as the remainder. A stop flag then makes every later stage pass those values through unchanged. A zero divisor never satisfies the stop condition, so it is detected as a separate case and given a defined result.

Top module: `calc_core`

## Requirements
- R1: Entries are taken in a fixed order: operand A, then operand B, then the operation. No result is flagged valid while the operands are being entered. Operation codes are 00 add, 01 subtract, 10 multiply, 11 divide.
- R2: `res_valid` rises on the clock edge that accepts the operation strobe, so it is visible one clock after that strobe. The result and flags are registered outputs.
- R3: For add, `res` holds the zero-extended sum A+B, and the carry-out sits in bit W. `rem_out`, `borrow` and `div_zero` are 0.
- R4: For subtract, `res[W-1:0]` holds (A-B) mod 2^W and the upper bits of `res` are 0. `borrow` is 1 exactly when B > A.
- R5: For multiply, `res` holds the full 2W-bit product A*B.
- R6: For divide with B != 0, `res[W-1:0]` is the quotient and the upper bits of `res` are 0. `rem_out` is the remainder, so A = q*B + r with r < B.
- R7: For divide with B = 0, the quotient is all ones, `rem_out` equals A, and `div_zero` is 1.
- R8: A strobe while a result is being shown starts a new entry, and its value becomes operand A. `res_valid`, `borrow` and `div_zero` fall on that edge.
- R9: A high `clr` returns the block to waiting for operand A from any state. On the next edge it drives `res`, `rem_out`, `res_valid`, `borrow` and `div_zero` to 0.
- R10: `ent_op` has no effect while an operand is being accepted. `ent_val` has no effect while the operation is being accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear back to operand A entry |
| ent_stb | input | 1 | One-cycle entry strobe |
| ent_val | input | W | Operand value for the entry |
| ent_op | input | 2 | Operation code for the entry |
| res | output | 2W | Registered result |
| rem_out | output | W | Registered remainder (divide only) |
| res_valid | output | 1 | Result is being shown |
| borrow | output | 1 | Subtract underflowed |
| div_zero | output | 1 | Divide by zero occurred |

## Verification
The bench builds the block with the default W = 4. This gives a 16-stage subtraction chain and an operand space of only 256 pairs. Every divisor and dividend pair, including every zero divisor, can therefore be driven and compared against a quotient-and-remainder model written in the bench. Directed vectors cover carry-out, borrow, the maximum product and the entry-order cases such as clear and restart.

// File: rtl/calc_pkg.sv
package calc_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } calc_op_e;

  typedef enum logic [1:0] {
    ST_WAIT_A  = 2'b00,
    ST_WAIT_B  = 2'b01,
    ST_WAIT_OP = 2'b10,
    ST_SHOW    = 2'b11
  } calc_st_e;

endpackage

// File: rtl/calc_seq.sv
module calc_seq
  import calc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ent_stb,
  input  logic [W-1:0] ent_val,
  input  logic [1:0]   ent_op,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output calc_op_e     op_q,
  output calc_st_e     st,
  output logic         evt_a,
  output logic         evt_b,
  output logic         evt_op
);

  // accepted entry events; clear wins over any strobe
  assign evt_a  = ent_stb && !clr && (st == ST_WAIT_A || st == ST_SHOW);
  assign evt_b  = ent_stb && !clr && (st == ST_WAIT_B);
  assign evt_op = ent_stb && !clr && (st == ST_WAIT_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_WAIT_A;
      a_q  <= '0;
      b_q  <= '0;
      op_q <= OP_ADD;
    end else if (clr) begin
      st <= ST_WAIT_A;
    end else begin
      if (evt_a) begin
        a_q <= ent_val;
        st  <= ST_WAIT_B;
      end
      if (evt_b) begin
        b_q <= ent_val;
        st  <= ST_WAIT_OP;
      end
      if (evt_op) begin
        op_q <= calc_op_e'(ent_op);
        st   <= ST_SHOW;
      end
    end
  end

endmodule

// File: rtl/calc_divarray.sv
module calc_divarray #(
  parameter int W = 4
) (
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         by_zero,
  output logic         resolved
);

  localparam int N = 1 << W;

  logic [N:0][W-1:0] run_v;
  logic [N:0][W-1:0] run_q;
  logic [N:0][W-1:0] run_r;
  logic [N:0]        stop;

  assign run_v[0] = dvd;
  assign run_q[0] = '0;
  assign run_r[0] = '0;
  assign stop[0]  = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    localparam logic [W-1:0] IDX = W'(i);
    logic hit;
    assign hit          = !stop[i] && (run_v[i] < dvs);
    assign stop[i+1]    = stop[i] | hit;
    assign run_v[i+1]   = (stop[i] | hit) ? run_v[i] : run_v[i] - dvs;
    assign run_q[i+1]   = hit ? IDX : run_q[i];
    assign run_r[i+1]   = hit ? run_v[i] : run_r[i];
  end

  // zero divisor never meets the stop test: handled outside the chain
  assign by_zero  = (dvs == '0);
  assign resolved = stop[N] | by_zero;
  assign quo      = by_zero ? '1  : run_q[N];
  assign rem      = by_zero ? dvd : run_r[N];

endmodule

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  calc_op_e       op,
  output logic [2*W-1:0] res,
  output logic [W-1:0]   rem,
  output logic           borrow,
  output logic           dz,
  output logic           div_done
);

  localparam int RW = 2 * W;

  function automatic logic [RW-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return RW'(s);
  endfunction

  function automatic logic [W:0] f_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] d;
    d = {1'b0, x} - {1'b0, y};
    return d;   // d[W] is the borrow
  endfunction

  function automatic logic [RW-1:0] f_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    return RW'(x) * RW'(y);
  endfunction

  logic [W-1:0] d_quo, d_rem;
  logic         d_zero;
  logic [W:0]   sub_w;

  calc_divarray #(.W(W)) u_div (
    .dvd      (a),
    .dvs      (b),
    .quo      (d_quo),
    .rem      (d_rem),
    .by_zero  (d_zero),
    .resolved (div_done)
  );

  assign sub_w = f_sub(a, b);

  always_comb begin
    res    = '0;
    rem    = '0;
    borrow = 1'b0;
    dz     = 1'b0;
    unique case (op)
      OP_ADD: res = f_add(a, b);
      OP_SUB: begin
        res    = RW'(sub_w[W-1:0]);
        borrow = sub_w[W];
      end
      OP_MUL: res = f_mul(a, b);
      OP_DIV: begin
        res = RW'(d_quo);
        rem = d_rem;
        dz  = d_zero;
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/calc_core.sv
module calc_core
  import calc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           ent_stb,
  input  logic [W-1:0]   ent_val,
  input  logic [1:0]     ent_op,
  output logic [2*W-1:0] res,
  output logic [W-1:0]   rem_out,
  output logic           res_valid,
  output logic           borrow,
  output logic           div_zero
);

  logic [W-1:0]   a_q, b_q;
  calc_op_e       op_q;
  calc_st_e       st;
  logic           evt_a, evt_b, evt_op;
  logic [2*W-1:0] alu_res;
  logic [W-1:0]   alu_rem;
  logic           alu_borrow, alu_dz, div_done;
  calc_op_e       op_now;

  calc_seq #(.W(W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .ent_stb (ent_stb),
    .ent_val (ent_val),
    .ent_op  (ent_op),
    .a_q     (a_q),
    .b_q     (b_q),
    .op_q    (op_q),
    .st      (st),
    .evt_a   (evt_a),
    .evt_b   (evt_b),
    .evt_op  (evt_op)
  );

  // compute with the operation being strobed in, so the answer lands on that edge
  assign op_now = calc_op_e'(ent_op);

  calc_alu #(.W(W)) u_alu (
    .a        (a_q),
    .b        (b_q),
    .op       (op_now),
    .res      (alu_res),
    .rem      (alu_rem),
    .borrow   (alu_borrow),
    .dz       (alu_dz),
    .div_done (div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res       <= '0;
      rem_out   <= '0;
      res_valid <= 1'b0;
      borrow    <= 1'b0;
      div_zero  <= 1'b0;
    end else if (clr) begin
      res       <= '0;
      rem_out   <= '0;
      res_valid <= 1'b0;
      borrow    <= 1'b0;
      div_zero  <= 1'b0;
    end else if (evt_op) begin
      res       <= alu_res;
      rem_out   <= alu_rem;
      res_valid <= 1'b1;
      borrow    <= alu_borrow;
      div_zero  <= alu_dz;
    end else if (evt_a) begin
      res_valid <= 1'b0;
      borrow    <= 1'b0;
      div_zero  <= 1'b0;
    end
  end

endmodule

// File: rtl/calc_core_chk.sv
module calc_core_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr,
  input logic           evt_a,
  input logic           evt_b,
  input logic           evt_op,
  input logic [1:0]     op_q,
  input logic [W-1:0]   b_q,
  input logic           div_done,
  input logic [2*W-1:0] res,
  input logic [W-1:0]   rem_out,
  input logic           res_valid,
  input logic           borrow,
  input logic           div_zero
);

  a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_a, evt_b, evt_op}));

  a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a || evt_b) |=> !res_valid);

  a_r2_valid_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    evt_op |=> res_valid);

  a_r4_borrow_only_sub: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |-> (res_valid && op_q == 2'b01));

  a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q == 2'b11 && !div_zero) |-> (rem_out < b_q));

  a_r6_chain_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q == 2'b11) |-> div_done);

  a_r7_zero_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (res_valid && res == {{W{1'b0}}, {W{1'b1}}}));

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!res_valid && !borrow && !div_zero));

endmodule

bind calc_core calc_core_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .evt_a     (evt_a),
  .evt_b     (evt_b),
  .evt_op    (evt_op),
  .op_q      (op_q),
  .b_q       (b_q),
  .div_done  (div_done),
  .res       (res),
  .rem_out   (rem_out),
  .res_valid (res_valid),
  .borrow    (borrow),
  .div_zero  (div_zero)
);

// File: tb/calc_core_test.sv
`timescale 1ns/1ps
module calc_core_test;

  localparam int W  = 4;
  localparam int NV = 13;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           clr = 1'b0;
  logic           ent_stb = 1'b0;
  logic [W-1:0]   ent_val = '0;
  logic [1:0]     ent_op = '0;
  logic [2*W-1:0] res;
  logic [W-1:0]   rem_out;
  logic           res_valid, borrow, div_zero;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  calc_core #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ent_stb(ent_stb),
    .ent_val(ent_val), .ent_op(ent_op), .res(res), .rem_out(rem_out),
    .res_valid(res_valid), .borrow(borrow), .div_zero(div_zero)
  );

  // a, b, op, expected res, expected rem, expected flag (borrow or div_zero)
  localparam logic [3:0] TA  [NV] = '{4'd7, 4'd15, 4'd3, 4'd9, 4'd15, 4'd6, 4'd13, 4'd15, 4'd2, 4'd9, 4'd0, 4'd5, 4'd12};
  localparam logic [3:0] TB  [NV] = '{4'd9, 4'd15, 4'd5, 4'd4, 4'd15, 4'd7, 4'd4, 4'd1, 4'd7, 4'd0, 4'd0, 4'd5, 4'd3};
  localparam logic [1:0] TOP [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd1, 2'd3};
  localparam logic [7:0] TR  [NV] = '{8'h10, 8'h1E, 8'h0E, 8'h05, 8'hE1, 8'h2A, 8'h03, 8'h0F, 8'h00, 8'h0F, 8'h0F, 8'h00, 8'h04};
  localparam logic [3:0] TM  [NV] = '{4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0, 4'd2, 4'd9, 4'd0, 4'd0, 4'd0};
  localparam logic       TF  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // packs {valid, res, rem, borrow, div_zero}
  function automatic logic [15:0] pack_out(input logic v, input logic [7:0] r, input logic [3:0] m,
                                           input logic bo, input logic dz);
    return {1'b0, v, r, m, bo, dz};
  endfunction

  task automatic put(input logic [3:0] v, input logic [1:0] o);
    ent_val = v; ent_op = o; ent_stb = 1'b1;
    @(negedge clk);
    ent_stb = 1'b0;
  endtask

  // operands entered with a misleading op code, operation with a junk value (R10)
  task automatic run(input logic [3:0] a, input logic [3:0] b, input logic [1:0] o);
    put(a, ~o);
    put(b, ~o);
    put(4'hA, o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset state", pack_out(res_valid, res, rem_out, borrow, div_zero), '0);

    // R1 ordering and R2 valid timing
    put(4'd5, 2'd2);
    check("R1 no valid after A", {15'd0, res_valid}, 16'd0);
    put(4'd6, 2'd2);
    check("R1 no valid after B", {15'd0, res_valid}, 16'd0);
    put(4'd0, 2'd2);
    check("R2 valid one clock after op, R5 product", pack_out(res_valid, res, rem_out, borrow, div_zero),
          pack_out(1'b1, 8'd30, 4'd0, 1'b0, 1'b0));

    // R8 restart from show
    put(4'd9, 2'd1);
    check("R8 restart drops valid", {15'd0, res_valid}, 16'd0);
    put(4'd2, 2'd0);
    put(4'd0, 2'd1);
    check("R8 new A used, R4 subtract", pack_out(res_valid, res, rem_out, borrow, div_zero),
          pack_out(1'b1, 8'd7, 4'd0, 1'b0, 1'b0));

    // table walk: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      run(TA[i], TB[i], TOP[i]);
      check($sformatf("R3/R4/R5/R6/R7 vector %0d", i), pack_out(res_valid, res, rem_out, borrow, div_zero),
            pack_out(1'b1, TR[i], TM[i], (TOP[i] == 2'd1) ? TF[i] : 1'b0, (TOP[i] == 2'd3) ? TF[i] : 1'b0));
    end

    // R9 clear mid-entry
    put(4'd3, 2'd0);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    put(4'd5, 2'd3);
    put(4'd2, 2'd3);
    put(4'd0, 2'd0);
    check("R9 clear mid-entry restarts at A", pack_out(res_valid, res, rem_out, borrow, div_zero),
          pack_out(1'b1, 8'd7, 4'd0, 1'b0, 1'b0));

    // R9 clear while showing a divide-by-zero result
    run(4'd4, 4'd0, 2'd3);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R9 clear while showing", pack_out(res_valid, res, rem_out, borrow, div_zero), '0);

    // R10 op code ignored during operands: divide op on A/B, then add
    put(4'd8, 2'd3);
    put(4'd8, 2'd3);
    put(4'd15, 2'd0);
    check("R10 op ignored on operands, value ignored on op", pack_out(res_valid, res, rem_out, borrow, div_zero),
          pack_out(1'b1, 8'h10, 4'd0, 1'b0, 1'b0));

    // R6 R7 exhaustive divide against a counting model
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int q, r;
        if (b == 0) begin
          q = 15; r = a;
        end else begin
          q = 0; r = a;
          while (r >= b) begin r = r - b; q++; end
        end
        run(4'(a), 4'(b), 2'd3);
        check($sformatf("R6/R7 divide %0d by %0d", a, b), pack_out(res_valid, res, rem_out, borrow, div_zero),
              pack_out(1'b1, 8'(q), 4'(r), 1'b0, (b == 0)));
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule